// File: doc/BRIEF.md
# Banked MSI and INTx Interrupt Aggregator

This block gathers inbound message-signalled interrupts and legacy INTx level messages for a PCIe root port and reduces them to a single interrupt line toward the processor. There are 256 MSI vectors, split into 8 sets of 32. Each set has its own message-address, status and enable registers. An inbound MSI carries the global vector number as its data. It is accepted only when its address equals the message-address register of the set that the vector selects. When accepted, it sets one status bit in that set.

Each set reduces its enabled pending bits to one summary. That summary passes through a per-set gate and is then latched into a top-level status register. The top-level status register also holds four emulated INTx levels and three event flags (message, AER, power management). The output line is asserted while any top-level status bit has its top-level enable bit set. Software services the block through a simple register bus that reads and writes 32-bit words.

Top module: `irq_bank_agg`

## Requirements
- R1: An MSI with data value v (0..255) and an address equal to the message-address register of set v/32 sets bit v%32 of that set's status register. Set s places its message-address register at 0xC00+0x10·s, its status register at +0x4 and its enable register at +0x8. All three can be read back.
- R2: An MSI whose address differs from the message-address register of the selected set changes no status bit.
- R3: Writing 1 to a bit of a set's status register clears that bit. Bits written with 0 keep their value.
- R4: When an accepted MSI and a write-1-to-clear hit the same status bit in the same cycle, the bit ends set.
- R5: Set s is pending when any status bit is 1 and its enable bit is also 1. If bit s of the set-gate register (0x190) is also 1, top-level status bit 8+s (top status at 0x184) becomes 1 on the following clock edge. A gate bit of 0 keeps that top status bit at 0.
- R6: Writing 1 to top-level status bit 8+s clears it only while set s is no longer gated-pending. Otherwise the bit stays 1.
- R7: An INTx assert message for line n (0=A … 3=D) sets top-level status bit 24+n. Writing 1 to that bit has no effect until a deassert message for line n has arrived. After that, a write of 1 clears it.
- R8: A pulse on event input bit k (0 message, 1 AER, 2 power management) sets top-level status bit 28+k. Writing 1 clears it.
- R9: `irq_out` is 1 exactly when some top-level status bit and the same bit of the top-level enable register (0x180) are both 1.
- R10: After reset every register reads 0 and `irq_out` is 0.
- R11: Read data appears on `reg_rdata` one clock edge after `reg_rd` is sampled. Reads of addresses that hold no register return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| msi_valid | input | 1 | Inbound MSI write valid |
| msi_addr | input | 32 | Inbound MSI target address |
| msi_data | input | 8 | Inbound MSI data (global vector) |
| intx_valid | input | 1 | INTx message valid |
| intx_assert | input | 1 | 1 = assert message, 0 = deassert message |
| intx_line | input | 2 | INTx line (0=A … 3=D) |
| evt_pulse | input | 3 | Event pulses: message, AER, power management |
| irq_out | output | 1 | Summarized interrupt line |

## Verification
Two cases are hard to reach from the ports, because each needs an exact cycle and state. The first is a collision between an inbound MSI and a software clear of the same status bit. The stimulus drives the MSI strobe and the status write on the same clock edge and then reads the bit back. The second is the INTx hold. The bench tries to clear the status bit while the level is still asserted, then sends the deassert message, checks that the bit is still set, and only then clears it. It also clears a top-level set summary while the set is still pending, to show that the summary is re-set, before it clears the set's own status.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned REG_AW = 12;
    localparam int unsigned REG_DW = 32;

    localparam logic [REG_AW-1:0] TOP_EN_ADDR = 12'h180;
    localparam logic [REG_AW-1:0] TOP_ST_ADDR = 12'h184;
    localparam logic [REG_AW-1:0] SET_GATE_ADDR = 12'h190;
    localparam logic [REG_AW-1:0] BANK_BASE = 12'hC00;
    localparam int unsigned BANK_STRIDE = 16;

    localparam int unsigned SUM_LSB = 8;
    localparam int unsigned INTX_LSB = 24;
    localparam int unsigned NUM_INTX = 4;
    localparam int unsigned EVT_LSB = 28;
    localparam int unsigned NUM_EVT = 3;

    typedef enum logic [1:0] {
        FLD_MSGADDR = 2'd0,
        FLD_STATUS = 2'd1,
        FLD_ENABLE = 2'd2,
        FLD_NONE = 2'd3
    } bank_fld_e;

    typedef struct packed {
        logic hit;
        logic [3:0] idx;
        bank_fld_e fld;
    } bank_sel_t;

    function automatic bank_sel_t decode_bank(input logic [REG_AW-1:0] a, input int unsigned nsets);
        bank_sel_t r;
        logic [REG_AW-1:0] off;
        off = a - BANK_BASE;
        r.idx = off[7:4];
        case (off[3:0])
            4'h0: r.fld = FLD_MSGADDR;
            4'h4: r.fld = FLD_STATUS;
            4'h8: r.fld = FLD_ENABLE;
            default: r.fld = FLD_NONE;
        endcase
        r.hit = (a >= BANK_BASE) && (32'(off) < nsets * BANK_STRIDE) && (r.fld != FLD_NONE);
        return r;
    endfunction

endpackage

// File: rtl/msi_set_bank.sv
module msi_set_bank
    import irq_agg_pkg::*;
#(
    parameter int unsigned VEC_PER_SET = 32,
    localparam int unsigned BIT_W = $clog2(VEC_PER_SET)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  bank_fld_e              fld,
    input  logic [REG_DW-1:0]      wdata,
    input  logic                   hit,
    input  logic [BIT_W-1:0]       hit_bit,
    output logic [REG_DW-1:0]      msg_addr,
    output logic [VEC_PER_SET-1:0] status,
    output logic [VEC_PER_SET-1:0] enable,
    output logic                   pending
);

    logic [VEC_PER_SET-1:0] clr_mask;
    logic [VEC_PER_SET-1:0] set_mask;
    logic [VEC_PER_SET-1:0] status_nxt;

    always_comb begin
        clr_mask = (wr_en && fld == FLD_STATUS) ? wdata[VEC_PER_SET-1:0] : '0;
        set_mask = hit ? (VEC_PER_SET'(1) << hit_bit) : '0;
        // a new message outranks a simultaneous clear
        status_nxt = (status & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_addr <= '0;
            status   <= '0;
            enable   <= '0;
        end else begin
            if (wr_en && fld == FLD_MSGADDR) msg_addr <= wdata;
            if (wr_en && fld == FLD_ENABLE) enable <= wdata[VEC_PER_SET-1:0];
            status <= status_nxt;
        end
    end

    assign pending = |(status & enable);

endmodule

// File: rtl/top_irq_ctrl.sv
module top_irq_ctrl
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_SETS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_DW-1:0]   wdata,
    input  logic                en_sel,
    input  logic                st_sel,
    input  logic                gate_sel,
    input  logic [NUM_SETS-1:0] bank_pend,
    input  logic                intx_valid,
    input  logic                intx_assert,
    input  logic [1:0]          intx_line,
    input  logic [NUM_EVT-1:0]  evt_pulse,
    output logic [REG_DW-1:0]   top_en,
    output logic [REG_DW-1:0]   top_st,
    output logic [NUM_SETS-1:0] set_gate,
    output logic [NUM_INTX-1:0] intx_lvl,
    output logic                irq
);

    localparam logic [REG_DW-1:0] WR_MASK =
        ((REG_DW'(1) << NUM_SETS) - REG_DW'(1)) << SUM_LSB |
        ((REG_DW'(1) << NUM_INTX) - REG_DW'(1)) << INTX_LSB |
        ((REG_DW'(1) << NUM_EVT) - REG_DW'(1)) << EVT_LSB;

    logic [REG_DW-1:0]   clr;
    logic [REG_DW-1:0]   st_nxt;
    logic [NUM_SETS-1:0] gated;

    always_comb begin
        clr    = (wr_en && st_sel) ? wdata : '0;
        gated  = bank_pend & set_gate;
        st_nxt = '0;
        st_nxt[SUM_LSB +: NUM_SETS] = (top_st[SUM_LSB +: NUM_SETS] & ~clr[SUM_LSB +: NUM_SETS]) | gated;
        // an asserted level blocks its own clear
        st_nxt[INTX_LSB +: NUM_INTX] = (top_st[INTX_LSB +: NUM_INTX] & ~(clr[INTX_LSB +: NUM_INTX] & ~intx_lvl))
                                       | intx_lvl;
        st_nxt[EVT_LSB +: NUM_EVT] = (top_st[EVT_LSB +: NUM_EVT] & ~clr[EVT_LSB +: NUM_EVT]) | evt_pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_en   <= '0;
            top_st   <= '0;
            set_gate <= '0;
            intx_lvl <= '0;
        end else begin
            if (wr_en && en_sel) top_en <= wdata & WR_MASK;
            if (wr_en && gate_sel) set_gate <= wdata[NUM_SETS-1:0];
            if (intx_valid) intx_lvl[intx_line] <= intx_assert;
            top_st <= st_nxt;
        end
    end

    assign irq = |(top_st & top_en);

endmodule

// File: rtl/irq_bank_agg.sv
module irq_bank_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_SETS = 8,
    parameter int unsigned VEC_PER_SET = 32,
    localparam int unsigned BIT_W = $clog2(VEC_PER_SET),
    localparam int unsigned SET_W = $clog2(NUM_SETS),
    localparam int unsigned VEC_W = BIT_W + SET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              msi_valid,
    input  logic [REG_DW-1:0] msi_addr,
    input  logic [VEC_W-1:0]  msi_data,
    input  logic              intx_valid,
    input  logic              intx_assert,
    input  logic [1:0]        intx_line,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic              irq_out
);

    bank_sel_t sel;
    logic [SET_W-1:0] msi_set;
    logic [BIT_W-1:0] msi_bit;
    logic             msi_accept;

    logic [REG_DW-1:0]      bank_addr [NUM_SETS];
    logic [VEC_PER_SET-1:0] bank_st   [NUM_SETS];
    logic [VEC_PER_SET-1:0] bank_en   [NUM_SETS];
    logic [NUM_SETS-1:0]    bank_pend;

    logic [REG_DW-1:0]           top_en;
    logic [REG_DW-1:0]           top_st;
    logic [NUM_SETS-1:0]         set_gate;
    logic [NUM_INTX-1:0]         intx_lvl;
    logic [NUM_SETS*REG_DW-1:0]  addr_flat;
    logic [NUM_SETS*VEC_PER_SET-1:0] st_flat;
    logic [REG_DW-1:0]           rd_val;

    assign sel        = decode_bank(reg_addr, NUM_SETS);
    assign msi_set    = msi_data[VEC_W-1:BIT_W];
    assign msi_bit    = msi_data[BIT_W-1:0];
    assign msi_accept = msi_valid && (msi_addr == bank_addr[msi_set]);

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_bank
        msi_set_bank #(.VEC_PER_SET(VEC_PER_SET)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (reg_wr && sel.hit && sel.idx == 4'(s)),
            .fld      (sel.fld),
            .wdata    (reg_wdata),
            .hit      (msi_accept && msi_set == SET_W'(s)),
            .hit_bit  (msi_bit),
            .msg_addr (bank_addr[s]),
            .status   (bank_st[s]),
            .enable   (bank_en[s]),
            .pending  (bank_pend[s])
        );
        assign addr_flat[s*REG_DW +: REG_DW] = bank_addr[s];
        assign st_flat[s*VEC_PER_SET +: VEC_PER_SET] = bank_st[s];
    end

    top_irq_ctrl #(.NUM_SETS(NUM_SETS)) u_top (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .wdata      (reg_wdata),
        .en_sel     (reg_addr == TOP_EN_ADDR),
        .st_sel     (reg_addr == TOP_ST_ADDR),
        .gate_sel   (reg_addr == SET_GATE_ADDR),
        .bank_pend  (bank_pend),
        .intx_valid (intx_valid),
        .intx_assert(intx_assert),
        .intx_line  (intx_line),
        .evt_pulse  (evt_pulse),
        .top_en     (top_en),
        .top_st     (top_st),
        .set_gate   (set_gate),
        .intx_lvl   (intx_lvl),
        .irq        (irq_out)
    );

    always_comb begin
        rd_val = '0;
        if (reg_addr == TOP_EN_ADDR) rd_val = top_en;
        else if (reg_addr == TOP_ST_ADDR) rd_val = top_st;
        else if (reg_addr == SET_GATE_ADDR) rd_val = REG_DW'(set_gate);
        else if (sel.hit) begin
            case (sel.fld)
                FLD_MSGADDR: rd_val = bank_addr[sel.idx[SET_W-1:0]];
                FLD_STATUS:  rd_val = REG_DW'(bank_st[sel.idx[SET_W-1:0]]);
                FLD_ENABLE:  rd_val = REG_DW'(bank_en[sel.idx[SET_W-1:0]]);
                default:     rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_val;
    end

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_SETS = 8,
    parameter int unsigned VEC_PER_SET = 32,
    parameter int unsigned VEC_W = 8
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            msi_valid,
    input logic [REG_DW-1:0]               msi_addr,
    input logic [VEC_W-1:0]                msi_data,
    input logic                            irq_out,
    input logic [REG_DW-1:0]               top_en,
    input logic [REG_DW-1:0]               top_st,
    input logic [NUM_SETS-1:0]             set_gate,
    input logic [NUM_SETS-1:0]             bank_pend,
    input logic [NUM_INTX-1:0]             intx_lvl,
    input logic [NUM_SETS*REG_DW-1:0]      addr_flat,
    input logic [NUM_SETS*VEC_PER_SET-1:0] st_flat
);

    logic msi_ok;
    assign msi_ok = msi_valid &&
        (msi_addr == addr_flat[32'(msi_data) / VEC_PER_SET * REG_DW +: REG_DW]);

    AST_MSI_LANDS: assert property (@(posedge clk) disable iff (rst)
        msi_ok |=> st_flat[$past(msi_data)]); // R4

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (top_en != '0)); // R9

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !irq_out); // R10

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_sum
        AST_SUMMARY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
            (bank_pend[s] && set_gate[s]) |=> top_st[SUM_LSB + s]); // R5
    end

    for (genvar n = 0; n < NUM_INTX; n++) begin : g_intx
        AST_INTX_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (intx_lvl[n] && top_st[INTX_LSB + n]) |=> top_st[INTX_LSB + n]); // R7
    end

endmodule

bind irq_bank_agg irq_agg_checker #(
    .NUM_SETS(NUM_SETS), .VEC_PER_SET(VEC_PER_SET), .VEC_W(VEC_W)
) u_chk (
    .clk(clk), .rst(rst), .msi_valid(msi_valid), .msi_addr(msi_addr),
    .msi_data(msi_data), .irq_out(irq_out), .top_en(top_en), .top_st(top_st),
    .set_gate(set_gate), .bank_pend(bank_pend), .intx_lvl(intx_lvl),
    .addr_flat(addr_flat), .st_flat(st_flat)
);

// File: tb/tb_irq_bank_agg.sv
`timescale 1ns/1ps
module tb_irq_bank_agg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msi_valid = 1'b0;
    logic [31:0] msi_addr = '0;
    logic [7:0]  msi_data = '0;
    logic        intx_valid = 1'b0, intx_assert = 1'b0;
    logic [1:0]  intx_line = '0;
    logic [2:0]  evt_pulse = '0;
    logic        irq_out;

    int n_chk = 0, n_fail = 0;
    logic rd_d = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    irq_bank_agg dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
        .msi_addr(msi_addr), .msi_data(msi_data), .intx_valid(intx_valid),
        .intx_assert(intx_assert), .intx_line(intx_line), .evt_pulse(evt_pulse),
        .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard queue
    always @(posedge clk) rd_d <= reg_rd;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) check("R11 unexpected read", reg_rdata, 32'h0);
            else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    task automatic rd_expect(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic msi(input logic [31:0] a, input logic [7:0] v);
        @(negedge clk);
        msi_valid = 1'b1; msi_addr = a; msi_data = v;
        @(negedge clk);
        msi_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic msi_and_clear(input logic [31:0] a, input logic [7:0] v,
                                 input logic [11:0] ra, input logic [31:0] d);
        @(negedge clk);
        msi_valid = 1'b1; msi_addr = a; msi_data = v;
        reg_wr = 1'b1; reg_addr = ra; reg_wdata = d;
        @(negedge clk);
        msi_valid = 1'b0; reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic intx(input logic [1:0] line, input logic asrt);
        @(negedge clk);
        intx_valid = 1'b1; intx_line = line; intx_assert = asrt;
        @(negedge clk);
        intx_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 irq in reset", {31'b0, irq_out}, 32'h0);
        rst = 1'b0;
        rd_expect(12'h184, 32'h0, "R10 top status");
        rd_expect(12'hC04, 32'h0, "R10 set0 status");
        rd_expect(12'h180, 32'h0, "R10 top enable");

        wr(12'hC00, 32'h1000_0C00);
        wr(12'hC30, 32'h1000_0C30);
        wr(12'hC70, 32'h1000_0C70);
        rd_expect(12'hC30, 32'h1000_0C30, "R1 msg addr readback");

        msi(32'h1000_0C30, 8'd99);                    // set 3 bit 3
        rd_expect(12'hC34, 32'h8, "R1 vector 99");
        msi(32'h1000_0C00, 8'd100);                   // wrong address for set 3
        rd_expect(12'hC34, 32'h8, "R2 mismatched address ignored");

        wr(12'hC38, 32'h8);
        rd_expect(12'hC38, 32'h8, "R1 enable readback");
        rd_expect(12'h184, 32'h0, "R5 gate closed");
        wr(12'h190, 32'h8);
        rd_expect(12'h184, 32'h800, "R5 summary bit 11");
        check("R9 irq masked", {31'b0, irq_out}, 32'h0);
        wr(12'h180, 32'h800);
        check("R9 irq raised", {31'b0, irq_out}, 32'h1);

        wr(12'h184, 32'h800);
        rd_expect(12'h184, 32'h800, "R6 clear blocked while pending");

        msi_and_clear(32'h1000_0C30, 8'd99, 12'hC34, 32'h8);
        rd_expect(12'hC34, 32'h8, "R4 message beats clear");

        wr(12'hC34, 32'h8);
        rd_expect(12'hC34, 32'h0, "R3 status cleared");
        rd_expect(12'h184, 32'h800, "R6 summary sticky");
        wr(12'h184, 32'h800);
        rd_expect(12'h184, 32'h0, "R6 summary cleared");
        check("R9 irq dropped", {31'b0, irq_out}, 32'h0);

        msi(32'h1000_0C70, 8'd255);
        rd_expect(12'hC74, 32'h8000_0000, "R1 vector 255");
        msi(32'h1000_0C00, 8'd0);
        rd_expect(12'hC04, 32'h1, "R1 vector 0");
        wr(12'hC04, 32'h0);
        rd_expect(12'hC04, 32'h1, "R3 write zero keeps bit");

        intx(2'd2, 1'b1);
        rd_expect(12'h184, 32'h0400_0000, "R7 INTC set");
        wr(12'h184, 32'h0400_0000);
        rd_expect(12'h184, 32'h0400_0000, "R7 clear blocked while asserted");
        intx(2'd2, 1'b0);
        rd_expect(12'h184, 32'h0400_0000, "R7 held after deassert");
        wr(12'h184, 32'h0400_0000);
        rd_expect(12'h184, 32'h0, "R7 cleared after deassert");

        @(negedge clk); evt_pulse = 3'b010;
        @(negedge clk); evt_pulse = 3'b000;
        @(negedge clk);
        rd_expect(12'h184, 32'h2000_0000, "R8 AER event");
        wr(12'h180, 32'h2000_0800);
        check("R9 irq from event", {31'b0, irq_out}, 32'h1);
        wr(12'h184, 32'h2000_0000);
        rd_expect(12'h184, 32'h0, "R8 event cleared");
        check("R9 irq after event clear", {31'b0, irq_out}, 32'h0);

        rd_expect(12'h300, 32'h0, "R11 unmapped read");
        rd_expect(12'h190, 32'h8, "R11 gate readback");

        repeat (2) @(negedge clk);
        report();
    end

endmodule